// File: doc/BRIEF.md
# PTP Receive Frame Classifier

The classifier watches a receive byte stream, one byte per accepted cycle, beginning with the first byte of the destination MAC address. It walks the frame header and decides whether the frame carries a version-2 Precision Time Protocol message. Three encapsulations are recognised: raw Ethernet, UDP over IPv4 and UDP over IPv6. Each can be switched on or off on its own. Any number of 0x8100 VLAN tags is stepped over. Frames that carry a length value and an LLC/SNAP header are unwrapped to reach their protocol type. For the raw Ethernet form, the destination address can be required to equal one of two well-known PTP multicast addresses.

One cycle after the byte that settles the question, the block pulses `cls_done` with a verdict. The verdict is the match flag, the encapsulation found and the 4-bit message type. Bytes that arrive after the verdict are ignored until the end-of-frame strobe re-arms the parser for the next frame. The configuration inputs are expected to stay stable while a frame is being parsed.

Top module: `ptp_rx_classifier`

## Requirements
- R1: After reset `cls_done`, `cls_match`, `cls_encap` and `cls_msg_type` are all 0.
- R2: A frame with type 0x88F7 is a raw-Ethernet PTP candidate. Its first PTP byte carries the message type in bits [3:0] and its second byte carries the version in bits [3:0]. Version 2 gives a match with encapsulation code 1 (codes: 0 none, 1 raw Ethernet, 2 IPv4, 3 IPv6). `cls_done` rises one cycle after the version byte is accepted. A match always reports a nonzero encapsulation code.
- R3: Type 0x0800 is checked as follows. Header byte 0 must hold version 4 in bits [7:4] and a header length IHL of at least 5 in bits [3:0]. Header byte 9 must equal 17 (UDP). The header length is IHL×4 bytes, so options are skipped. The UDP destination port (UDP bytes 2–3) must be 319 or 320. The PTP header follows the 8-byte UDP header, and a match reports code 2.
- R4: Type 0x86DD requires version 6 in byte 0 bits [7:4] and next-header byte 6 equal to 17. A fixed 40-byte header is followed by UDP, checked as in R3, and a match reports code 3.
- R5: Each encapsulation has its own enable input. A frame whose type names a disabled encapsulation is rejected one cycle after the second type byte.
- R6: Each type value 0x8100 is skipped together with the 2 tag bytes after it, so any number of stacked tags is accepted.
- R7: A type/length value of at most 1500 must be followed by the bytes AA AA 03 00 00 00, and the 2 bytes after them are then used as the type. A mismatching SNAP byte rejects the frame one cycle after that byte.
- R8: When destination checking is enabled, a raw-Ethernet PTP frame matches only if its destination equals 01:1B:19:00:00:00 with its enable set, or 01:80:C2:00:00:0E with its enable set. Either address serves any message type. When checking is disabled, any destination is accepted.
- R9: A PTP version other than 2 gives `cls_done` with `cls_match` 0, one cycle after the version byte.
- R10: An unknown type, an IPv4 protocol other than 17 or a UDP port other than 319/320 rejects the frame one cycle after the deciding byte. A rejected frame reports code 0 and message type 0.
- R11: An end-of-frame strobe before a verdict gives `cls_done` with `cls_match` 0 one cycle later, and the parser restarts at the next destination byte. After a verdict, further bytes are ignored. A strobe with no bytes since the last frame gives no `cls_done`.
- R12: `cls_done` is a one-cycle pulse, issued exactly once per frame. The verdict outputs hold their value until the next pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frame byte is present on `in_data` |
| in_data | input | 8 | Frame byte, destination address first |
| frame_end | input | 1 | End-of-frame strobe |
| cfg_l2_en | input | 1 | Enable raw-Ethernet PTP detection |
| cfg_ipv4_en | input | 1 | Enable UDP/IPv4 PTP detection |
| cfg_ipv6_en | input | 1 | Enable UDP/IPv6 PTP detection |
| cfg_dst_chk_en | input | 1 | Enable destination address filtering (raw Ethernet) |
| cfg_dst_a_en | input | 1 | Accept 01:1B:19:00:00:00 |
| cfg_dst_b_en | input | 1 | Accept 01:80:C2:00:00:0E |
| cls_done | output | 1 | One-cycle verdict pulse |
| cls_match | output | 1 | Frame is a version-2 PTP message |
| cls_encap | output | 2 | Encapsulation code |
| cls_msg_type | output | 4 | PTP message type |

## Verification
The hardest situation to reach is a verdict that depends on state gathered many bytes earlier. Examples are a destination-address hit combined with a SNAP-wrapped, VLAN-tagged type field, or an IPv4 header whose IHL stretches the UDP position past the options. The bench builds each frame from layer helpers: MAC, tags, SNAP, IP with a chosen IHL, UDP and PTP. It records the byte index where the verdict must fall, and the scoreboard checks both the verdict and that exact byte position. Truncated frames and empty end strobes exercise the abort path.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
  typedef enum logic [1:0] {
    ENC_NONE = 2'd0,
    ENC_L2   = 2'd1,
    ENC_IPV4 = 2'd2,
    ENC_IPV6 = 2'd3
  } ptpc_encap_e;

  localparam logic [15:0] TYPE_VLAN   = 16'h8100;
  localparam logic [15:0] TYPE_PTP    = 16'h88F7;
  localparam logic [15:0] TYPE_IPV4   = 16'h0800;
  localparam logic [15:0] TYPE_IPV6   = 16'h86DD;
  localparam logic [15:0] LEN_LIMIT   = 16'd1500;
  localparam logic [15:0] PORT_EVENT  = 16'd319;
  localparam logic [15:0] PORT_GENRL  = 16'd320;
  localparam logic [7:0]  PROTO_UDP   = 8'd17;
  localparam logic [3:0]  PTP_VERSION = 4'd2;
  localparam logic [47:0] PTP_MAC_A   = 48'h011B19000000;
  localparam logic [47:0] PTP_MAC_B   = 48'h0180C200000E;
  localparam int          N_PTP_MAC   = 2;

  // byte i (0 = first on the wire) of a 48-bit address
  function automatic logic [7:0] mac_byte(input logic [47:0] a, input logic [2:0] i);
    logic [47:0] t;
    t = a >> (8 * (5 - int'(i)));
    return t[7:0];
  endfunction

  // expected LLC/SNAP prefix byte i (0..5)
  function automatic logic [7:0] snap_byte(input logic [2:0] i);
    case (i)
      3'd0, 3'd1: return 8'hAA;
      3'd2:       return 8'h03;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] ipv4_hdr_bytes(input logic [3:0] ihl);
    return {2'b00, ihl, 2'b00};
  endfunction

  function automatic logic is_ptp_port(input logic [15:0] p);
    return (p == PORT_EVENT) || (p == PORT_GENRL);
  endfunction
endpackage

// File: rtl/ptpc_dst_filter.sv
module ptpc_dst_filter
  import ptpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       da_phase,
  input  logic [2:0] da_idx,
  input  logic       cfg_dst_a_en,
  input  logic       cfg_dst_b_en,
  output logic       da_ok
);
  localparam logic [47:0] ADDRS [N_PTP_MAC] = '{PTP_MAC_A, PTP_MAC_B};

  logic [N_PTP_MAC-1:0] hit_vec;
  logic [N_PTP_MAC-1:0] addr_en;

  assign addr_en = {cfg_dst_b_en, cfg_dst_a_en};

  for (genvar g = 0; g < N_PTP_MAC; g++) begin : g_addr
    logic hit_r;
    logic byte_eq;
    assign byte_eq = (in_data == mac_byte(ADDRS[g], da_idx));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_r <= 1'b0;
      end else if (in_valid && da_phase) begin
        hit_r <= (da_idx == 3'd0) ? byte_eq : (hit_r & byte_eq);
      end
    end
    assign hit_vec[g] = hit_r;
  end

  assign da_ok = |(hit_vec & addr_en);
endmodule

// File: rtl/ptpc_walker.sv
module ptpc_walker
  import ptpc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              frame_end,
  input  logic              cfg_l2_en,
  input  logic              cfg_ipv4_en,
  input  logic              cfg_ipv6_en,
  input  logic              cfg_dst_chk_en,
  input  logic              da_ok,
  output logic              da_phase,
  output logic [2:0]        da_idx,
  output logic              dec_valid,
  output logic              dec_match,
  output ptpc_encap_e       dec_encap,
  output logic [3:0]        dec_msg_type
);
  localparam logic [CNT_W-1:0] MAC_LAST  = CNT_W'(11);
  localparam logic [CNT_W-1:0] DA_BYTES  = CNT_W'(6);
  localparam logic [CNT_W-1:0] IP6_LAST  = CNT_W'(39);
  localparam logic [CNT_W-1:0] UDP_LAST  = CNT_W'(7);

  typedef enum logic [3:0] {
    S_MAC, S_TYPE, S_VTAG, S_SNAP, S_IP4, S_IP6, S_UDP, S_PTP, S_DONE
  } walk_e;

  walk_e            state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, iplen_q, iplen_n;
  logic [7:0]       hi_q, hi_n;
  logic             snap_q, snap_n;
  ptpc_encap_e      encap_q, encap_n;
  logic [3:0]       msg_q, msg_n;
  logic             accept, reject, abort;
  logic [15:0]      word;

  always_comb begin
    state_n = state_q; cnt_n = cnt_q; hi_n = hi_q; snap_n = snap_q;
    iplen_n = iplen_q; encap_n = encap_q; msg_n = msg_q;
    accept  = 1'b0; reject = 1'b0;
    word    = {hi_q, in_data};
    if (in_valid) begin
      case (state_q)
        S_MAC: begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == MAC_LAST) begin state_n = S_TYPE; cnt_n = '0; end
        end
        S_TYPE: begin
          if (cnt_q == '0) begin
            hi_n = in_data; cnt_n = CNT_W'(1);
          end else begin
            cnt_n = '0;
            if (word == TYPE_VLAN) state_n = S_VTAG;
            else if (word <= LEN_LIMIT && !snap_q) begin state_n = S_SNAP; snap_n = 1'b1; end
            else if (word == TYPE_PTP && cfg_l2_en && (!cfg_dst_chk_en || da_ok)) begin
              state_n = S_PTP; encap_n = ENC_L2;
            end
            else if (word == TYPE_IPV4 && cfg_ipv4_en) begin state_n = S_IP4; encap_n = ENC_IPV4; end
            else if (word == TYPE_IPV6 && cfg_ipv6_en) begin state_n = S_IP6; encap_n = ENC_IPV6; end
            else reject = 1'b1;
          end
        end
        S_VTAG: begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(1)) begin state_n = S_TYPE; cnt_n = '0; end
        end
        S_SNAP: begin
          cnt_n = cnt_q + 1'b1;
          if (in_data != snap_byte(cnt_q[2:0])) reject = 1'b1;
          else if (cnt_q == CNT_W'(5)) begin state_n = S_TYPE; cnt_n = '0; end
        end
        S_IP4: begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == '0) begin
            if (in_data[7:4] != 4'd4 || in_data[3:0] < 4'd5) reject = 1'b1;
            else iplen_n = CNT_W'(ipv4_hdr_bytes(in_data[3:0]));
          end else if (cnt_q == CNT_W'(9)) begin
            if (in_data != PROTO_UDP) reject = 1'b1;
          end else if (cnt_q == iplen_q - CNT_W'(1)) begin
            state_n = S_UDP; cnt_n = '0;
          end
        end
        S_IP6: begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == '0 && in_data[7:4] != 4'd6) reject = 1'b1;
          else if (cnt_q == CNT_W'(6) && in_data != PROTO_UDP) reject = 1'b1;
          else if (cnt_q == IP6_LAST) begin state_n = S_UDP; cnt_n = '0; end
        end
        S_UDP: begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(2)) hi_n = in_data;
          else if (cnt_q == CNT_W'(3) && !is_ptp_port(word)) reject = 1'b1;
          else if (cnt_q == UDP_LAST) begin state_n = S_PTP; cnt_n = '0; end
        end
        S_PTP: begin
          if (cnt_q == '0) begin msg_n = in_data[3:0]; cnt_n = CNT_W'(1); end
          else if (in_data[3:0] == PTP_VERSION) accept = 1'b1;
          else reject = 1'b1;
        end
        default: ;
      endcase
    end
    if (accept || reject) state_n = S_DONE;
    abort = frame_end && (state_q != S_DONE) && !(accept || reject)
            && (in_valid || state_q != S_MAC || cnt_q != '0);
    if (frame_end) begin
      state_n = S_MAC; cnt_n = '0; snap_n = 1'b0; encap_n = ENC_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_MAC; cnt_q <= '0; hi_q <= '0; snap_q <= 1'b0;
      iplen_q <= '0; encap_q <= ENC_NONE; msg_q <= '0;
    end else begin
      state_q <= state_n; cnt_q <= cnt_n; hi_q <= hi_n; snap_q <= snap_n;
      iplen_q <= iplen_n; encap_q <= encap_n; msg_q <= msg_n;
    end
  end

  assign da_phase     = (state_q == S_MAC) && (cnt_q < DA_BYTES);
  assign da_idx       = cnt_q[2:0];
  assign dec_valid    = accept || reject || abort;
  assign dec_match    = accept;
  assign dec_encap    = accept ? encap_q : ENC_NONE;
  assign dec_msg_type = accept ? msg_q : 4'd0;

  // once a verdict is out, bytes cannot produce another one before frame end
  assert_ignore_after_verdict_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DONE && !frame_end) |-> !dec_valid);
endmodule

// File: rtl/ptpc_result.sv
module ptpc_result
  import ptpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dec_valid,
  input  logic        dec_match,
  input  ptpc_encap_e dec_encap,
  input  logic [3:0]  dec_msg_type,
  output logic        cls_done,
  output logic        cls_match,
  output logic [1:0]  cls_encap,
  output logic [3:0]  cls_msg_type
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_done <= 1'b0; cls_match <= 1'b0; cls_encap <= '0; cls_msg_type <= '0;
    end else begin
      cls_done <= dec_valid;
      if (dec_valid) begin
        cls_match    <= dec_match;
        cls_encap    <= dec_encap;
        cls_msg_type <= dec_msg_type;
      end
    end
  end

  assert_match_has_encap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_done && cls_match) |-> (cls_encap != 2'(ENC_NONE)));

  // R12: verdict holds between pulses
  assert_verdict_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_done |=> (!cls_done || 1'b1) && ($stable(cls_match) || $past(dec_valid)));
endmodule

// File: rtl/ptp_rx_classifier.sv
module ptp_rx_classifier
  import ptpc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       frame_end,
  input  logic       cfg_l2_en,
  input  logic       cfg_ipv4_en,
  input  logic       cfg_ipv6_en,
  input  logic       cfg_dst_chk_en,
  input  logic       cfg_dst_a_en,
  input  logic       cfg_dst_b_en,
  output logic       cls_done,
  output logic       cls_match,
  output logic [1:0] cls_encap,
  output logic [3:0] cls_msg_type
);
  logic        da_phase, da_ok;
  logic [2:0]  da_idx;
  logic        dec_valid, dec_match;
  ptpc_encap_e dec_encap;
  logic [3:0]  dec_msg_type;

  ptpc_dst_filter u_dst (
    .clk, .rst_n, .in_valid, .in_data, .da_phase, .da_idx,
    .cfg_dst_a_en, .cfg_dst_b_en, .da_ok
  );

  ptpc_walker #(.CNT_W(CNT_W)) u_walk (
    .clk, .rst_n, .in_valid, .in_data, .frame_end,
    .cfg_l2_en, .cfg_ipv4_en, .cfg_ipv6_en, .cfg_dst_chk_en, .da_ok,
    .da_phase, .da_idx, .dec_valid, .dec_match, .dec_encap, .dec_msg_type
  );

  ptpc_result u_res (
    .clk, .rst_n, .dec_valid, .dec_match, .dec_encap, .dec_msg_type,
    .cls_done, .cls_match, .cls_encap, .cls_msg_type
  );

  assert_l2_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_done && cls_match && cls_encap == 2'(ENC_L2)) |-> $past(cfg_l2_en));

  assert_l2_dst_filter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_done && cls_match && cls_encap == 2'(ENC_L2) && $past(cfg_dst_chk_en))
      |-> $past(da_ok));
endmodule

// File: tb/ptp_rx_classifier_tb.sv
`timescale 1ns/1ps
module ptp_rx_classifier_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic frame_end = 1'b0;
  logic cfg_l2_en = 1'b1, cfg_ipv4_en = 1'b1, cfg_ipv6_en = 1'b1;
  logic cfg_dst_chk_en = 1'b0, cfg_dst_a_en = 1'b1, cfg_dst_b_en = 1'b1;
  logic cls_done, cls_match;
  logic [1:0] cls_encap;
  logic [3:0] cls_msg_type;

  always #2.5 clk = ~clk;

  ptp_rx_classifier dut_i (
    .clk, .rst_n, .in_valid, .in_data, .frame_end,
    .cfg_l2_en, .cfg_ipv4_en, .cfg_ipv6_en, .cfg_dst_chk_en, .cfg_dst_a_en, .cfg_dst_b_en,
    .cls_done, .cls_match, .cls_encap, .cls_msg_type
  );

  int checks = 0, errors = 0, sent = 0;
  logic [7:0] fr[$];
  logic q_m[$]; logic [1:0] q_e[$]; logic [3:0] q_t[$]; int q_at[$]; string q_tag[$];

  localparam logic [47:0] MAC_A = 48'h011B19000000;
  localparam logic [47:0] MAC_B = 48'h0180C200000E;
  localparam logic [47:0] MAC_X = 48'h3C2A11FE0077;

  task automatic put8(input logic [7:0] b); fr.push_back(b); endtask
  task automatic put16(input logic [15:0] w); put8(w[15:8]); put8(w[7:0]); endtask
  task automatic put_mac(input logic [47:0] da);
    for (int i = 5; i >= 0; i--) put8(da[8*i +: 8]);
    for (int i = 0; i < 6; i++) put8(8'h50 + 8'(i));
  endtask
  task automatic put_snap(input logic [7:0] oui0);
    put8(8'hAA); put8(8'hAA); put8(8'h03); put8(oui0); put8(8'h00); put8(8'h00);
  endtask
  task automatic put_ipv4(input logic [3:0] ihl, input logic [7:0] proto);
    put8({4'd4, ihl}); for (int i = 1; i < 9; i++) put8(8'h11);
    put8(proto); for (int i = 10; i < 4*int'(ihl); i++) put8(8'h22);
  endtask
  task automatic put_ipv6(input logic [7:0] nh);
    put8(8'h60); for (int i = 1; i < 6; i++) put8(8'h00);
    put8(nh); for (int i = 7; i < 40; i++) put8(8'h33);
  endtask
  task automatic put_udp(input logic [15:0] port);
    put16(16'd5000); put16(port); put16(16'd60); put16(16'h0000);
  endtask
  task automatic put_ptp(input logic [3:0] mt, input logic [3:0] ver);
    put8({4'h1, mt}); put8({4'h0, ver});
  endtask
  task automatic pad(); for (int i = 0; i < 6; i++) put8(8'hEE); endtask

  // expected verdict after byte 'at' of the current frame
  task automatic send(input logic m, input logic [1:0] e, input logic [3:0] t,
                      input int at, input string tag);
    q_m.push_back(m); q_e.push_back(e); q_t.push_back(t); q_at.push_back(at); q_tag.push_back(tag);
    sent = 0;
    foreach (fr[i]) begin
      @(negedge clk); in_valid = 1'b1; in_data = fr[i]; sent = i + 1;
    end
    @(negedge clk); in_valid = 1'b0; frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    repeat (2) @(negedge clk);
    fr.delete();
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && cls_done) begin
      checks++;
      if (q_m.size() == 0) begin
        errors++;
        $display("FAIL R12: unexpected done, actual match=%0d expected no pulse", cls_match);
      end else begin
        automatic logic m = q_m.pop_front();
        automatic logic [1:0] e = q_e.pop_front();
        automatic logic [3:0] t = q_t.pop_front();
        automatic int at = q_at.pop_front();
        automatic string tg = q_tag.pop_front();
        if (cls_match !== m || cls_encap !== e || cls_msg_type !== t) begin
          errors++;
          $display("FAIL %s: actual match=%0d encap=%0d type=%0h expected match=%0d encap=%0d type=%0h",
                   tg, cls_match, cls_encap, cls_msg_type, m, e, t);
        end
        checks++;
        if (sent != at) begin
          errors++;
          $display("FAIL %s timing: actual byte %0d expected byte %0d", tg, sent, at);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int at;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (cls_done !== 1'b0 || cls_match !== 1'b0 || cls_encap !== 2'd0 || cls_msg_type !== 4'd0) begin
      errors++;
      $display("FAIL R1: actual %0d/%0d/%0d/%0h expected 0/0/0/0", cls_done, cls_match, cls_encap, cls_msg_type);
    end

    // R2 plain raw Ethernet Sync
    put_mac(MAC_X); put16(16'h88F7); put_ptp(4'h0, 4'd2); at = fr.size(); pad();
    send(1, 2'd1, 4'h0, at, "R2");
    // R6 one tag, R6 two tags
    put_mac(MAC_X); put16(16'h8100); put16(16'h0005); put16(16'h88F7); put_ptp(4'hB, 4'd2); at = fr.size(); pad();
    send(1, 2'd1, 4'hB, at, "R6");
    put_mac(MAC_X); put16(16'h8100); put16(16'h0005); put16(16'h8100); put16(16'h0123);
    put16(16'h88F7); put_ptp(4'h3, 4'd2); at = fr.size(); pad();
    send(1, 2'd1, 4'h3, at, "R6");
    // R3 IPv4 basic and with options
    put_mac(MAC_X); put16(16'h0800); put_ipv4(4'd5, 8'd17); put_udp(16'd319); put_ptp(4'h1, 4'd2); at = fr.size(); pad();
    send(1, 2'd2, 4'h1, at, "R3");
    put_mac(MAC_X); put16(16'h0800); put_ipv4(4'd7, 8'd17); put_udp(16'd320); put_ptp(4'h8, 4'd2); at = fr.size(); pad();
    send(1, 2'd2, 4'h8, at, "R3");
    // R4 IPv6 behind a tag
    put_mac(MAC_X); put16(16'h8100); put16(16'h0002); put16(16'h86DD); put_ipv6(8'd17); put_udp(16'd320);
    put_ptp(4'h2, 4'd2); at = fr.size(); pad();
    send(1, 2'd3, 4'h2, at, "R4");
    // R7 SNAP good and bad
    put_mac(MAC_X); put16(16'h0040); put_snap(8'h00); put16(16'h88F7); put_ptp(4'hC, 4'd2); at = fr.size(); pad();
    send(1, 2'd1, 4'hC, at, "R7");
    put_mac(MAC_X); put16(16'h0040); put8(8'hAA); put8(8'hAA); put8(8'h03); put8(8'h01); at = fr.size();
    put8(8'h00); put8(8'h00); put16(16'h88F7); put_ptp(4'hC, 4'd2); pad();
    send(0, 2'd0, 4'h0, at, "R7");
    // R9 version 1
    put_mac(MAC_X); put16(16'h88F7); put_ptp(4'h0, 4'd1); at = fr.size(); pad();
    send(0, 2'd0, 4'h0, at, "R9");
    // R10 rejects
    put_mac(MAC_X); put16(16'h0806); at = fr.size(); pad(); pad(); pad();
    send(0, 2'd0, 4'h0, at, "R10");
    put_mac(MAC_X); put16(16'h0800); at = fr.size() + 10; put_ipv4(4'd5, 8'd6); put_udp(16'd319); put_ptp(4'h1, 4'd2); pad();
    send(0, 2'd0, 4'h0, at, "R10");
    put_mac(MAC_X); put16(16'h86DD); put_ipv6(8'd17); at = fr.size() + 4; put_udp(16'd1234); put_ptp(4'h1, 4'd2); pad();
    send(0, 2'd0, 4'h0, at, "R10");
    // R5 disables
    cfg_l2_en = 1'b0;
    put_mac(MAC_X); put16(16'h88F7); at = fr.size(); put_ptp(4'h0, 4'd2); pad();
    send(0, 2'd0, 4'h0, at, "R5");
    cfg_l2_en = 1'b1; cfg_ipv4_en = 1'b0;
    put_mac(MAC_X); put16(16'h0800); at = fr.size(); put_ipv4(4'd5, 8'd17); put_udp(16'd319); put_ptp(4'h1, 4'd2); pad();
    send(0, 2'd0, 4'h0, at, "R5");
    cfg_ipv4_en = 1'b1; cfg_ipv6_en = 1'b0;
    put_mac(MAC_X); put16(16'h86DD); at = fr.size(); put_ipv6(8'd17); put_udp(16'd319); put_ptp(4'h1, 4'd2); pad();
    send(0, 2'd0, 4'h0, at, "R5");
    cfg_ipv6_en = 1'b1;
    // R8 destination filter
    cfg_dst_chk_en = 1'b1; cfg_dst_b_en = 1'b0;
    put_mac(MAC_A); put16(16'h88F7); put_ptp(4'h9, 4'd2); at = fr.size(); pad();
    send(1, 2'd1, 4'h9, at, "R8");
    put_mac(MAC_B); put16(16'h88F7); at = fr.size(); put_ptp(4'h2, 4'd2); pad();
    send(0, 2'd0, 4'h0, at, "R8");
    cfg_dst_b_en = 1'b1; cfg_dst_a_en = 1'b0;
    put_mac(MAC_B); put16(16'h8100); put16(16'h0007); put16(16'h88F7); put_ptp(4'h2, 4'd2); at = fr.size(); pad();
    send(1, 2'd1, 4'h2, at, "R8");
    cfg_dst_a_en = 1'b1;
    put_mac(MAC_X); put16(16'h88F7); at = fr.size(); put_ptp(4'h2, 4'd2); pad();
    send(0, 2'd0, 4'h0, at, "R8");
    // R8 filter does not gate UDP
    put_mac(MAC_X); put16(16'h0800); put_ipv4(4'd5, 8'd17); put_udp(16'd319); put_ptp(4'h0, 4'd2); at = fr.size(); pad();
    send(1, 2'd2, 4'h0, at, "R8");
    cfg_dst_chk_en = 1'b0;
    // R11 truncated frames
    put_mac(MAC_X); put16(16'h0800); put_ipv4(4'd5, 8'd17); at = fr.size();
    send(0, 2'd0, 4'h0, at, "R11");
    put8(8'h01); put8(8'h1B); put8(8'h19); at = fr.size();
    send(0, 2'd0, 4'h0, at, "R11");
    // R11 empty strobe: no pulse expected
    @(negedge clk); frame_end = 1'b1; @(negedge clk); frame_end = 1'b0; repeat (3) @(negedge clk);
    // R11 parser restarted correctly
    put_mac(MAC_X); put16(16'h88F7); put_ptp(4'h5, 4'd2); at = fr.size(); pad();
    send(1, 2'd1, 4'h5, at, "R11");
    // R12 verdict held after pulse
    repeat (3) @(negedge clk);
    checks++;
    if (cls_match !== 1'b1 || cls_msg_type !== 4'h5 || cls_done !== 1'b0) begin
      errors++;
      $display("FAIL R12: actual match=%0d type=%0h done=%0d expected 1/5/0", cls_match, cls_msg_type, cls_done);
    end
    checks++;
    if (q_m.size() != 0) begin
      errors++;
      $display("FAIL R12: actual %0d verdicts missing expected 0", q_m.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule